// File: doc/BRIEF.md
# Delayed Transaction Retry Tracker

This target-side block stores read requests that cannot be answered straight away. Each such request is kept in a small table, and the initiator is told to retry. At the same time the block starts the access on a local request port. The initiator must later send exactly the same request again. When it does, the block looks for that request in its table. If the local completion has already come back, the block answers with the held data. If it has not, the block tells the initiator to retry again.

The table has a fixed number of slots, and one slot is enough for a simple target. When every slot is in use, a new request gets a retry and is not recorded. A completed slot that no initiator claims is freed after a programmable number of clock cycles, and its data is dropped. Any answer that carries no data drives all ones on the data lines.

Top module: `dly_txn_tracker`

## Requirements
- R1: Every request sampled on a clock edge produces exactly one response, visible in the cycle after that edge. No response appears in any other cycle.
- R2: A request is new when it matches no occupied slot. If a free slot exists, a new request is recorded in the lowest-numbered free slot as pending and answered with retry (`rsp_done_o`=0). In the next cycle the block issues a local request carrying the request's fields and the slot number as tag.
- R3: A request matches a slot only when the command, the address and the byte enables all equal the stored values. A difference in any one of these fields makes it a new request.
- R4: A matching request on a pending slot is answered with retry. No local request is issued, and the slot is unchanged.
- R5: A local completion whose tag names a pending slot stores the completion data and marks the slot complete. A completion whose tag names a slot that is not pending is ignored.
- R6: A matching request on a complete slot is answered with `rsp_done_o`=1 and the stored data, and the slot becomes free.
- R7: When all slots are occupied, a new request is answered with retry. It is not recorded, and no local request is issued.
- R8: Let E0 be the clock edge on which a slot becomes complete, and let N be the value of `discard_cycles_i`. A matching request sampled on any of the N+1 edges after E0 is served. If no matching request arrives on those edges, the slot is free from edge E0+N+1 onward.
- R9: Every retry response drives `rsp_data_o` to all ones.
- R10: After reset the table is empty, and no response and no local request are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| discard_cycles_i | input | DISC_W | Number of cycles a completed slot is held before it is freed |
| req_valid_i | input | 1 | A bus request is present in this cycle |
| req_cmd_i | input | CMD_W | Command code of the request |
| req_addr_i | input | ADDR_W | Address of the request |
| req_be_i | input | BE_W | Byte enables of the request |
| rsp_valid_o | output | 1 | A response is present |
| rsp_done_o | output | 1 | 1 means completed with data, 0 means retry |
| rsp_data_o | output | DATA_W | Returned data; all ones on a retry |
| loc_req_valid_o | output | 1 | A local access is being started |
| loc_req_tag_o | output | TAG_W | Slot number of the local access |
| loc_req_cmd_o | output | CMD_W | Command of the local access |
| loc_req_addr_o | output | ADDR_W | Address of the local access |
| loc_req_be_o | output | BE_W | Byte enables of the local access |
| loc_cpl_valid_i | input | 1 | A local completion is present |
| loc_cpl_tag_i | input | TAG_W | Slot number that the completion belongs to |
| loc_cpl_data_i | input | DATA_W | Completion data |

## Verification
The bus response and the local request both come from registers. They are due in the cycle that follows the edge on which the request was sampled. A completion takes effect on its own edge, so a request sampled on that same edge still receives a retry. The bench changes its inputs on the falling edge and runs its model of the table for the next rising edge. It then compares every output 1 ns after that edge, so each result is checked in exactly the cycle it is due. The discard window is probed both on its last serving edge and on the first edge after it.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [1:0] {
    ENT_EMPTY = 2'd0,
    ENT_PEND  = 2'd1,
    ENT_CPL   = 2'd2
  } ent_st_e;
endpackage

// File: rtl/dtt_entry.sv
module dtt_entry
  import dtt_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int DATA_W = 32,
  parameter int DISC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_i,
  input  logic [CMD_W-1:0]  rec_cmd_i,
  input  logic [ADDR_W-1:0] rec_addr_i,
  input  logic [BE_W-1:0]   rec_be_i,
  input  logic              take_i,
  input  logic              cpl_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  input  logic [DISC_W-1:0] limit_i,
  output ent_st_e           state_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic [DATA_W-1:0] data_o
);
  ent_st_e           state_q;
  logic [DISC_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENT_EMPTY;
      age_q   <= '0;
      cmd_o   <= '0;
      addr_o  <= '0;
      be_o    <= '0;
      data_o  <= '0;
    end else if (rec_i) begin
      state_q <= ENT_PEND;
      cmd_o   <= rec_cmd_i;
      addr_o  <= rec_addr_i;
      be_o    <= rec_be_i;
    end else if (take_i) begin
      state_q <= ENT_EMPTY;
    end else if (state_q == ENT_PEND && cpl_i) begin
      state_q <= ENT_CPL;
      data_o  <= cpl_data_i;
      age_q   <= '0;
    end else if (state_q == ENT_CPL) begin
      // unclaimed data is dropped once the hold window has run out
      if (age_q == limit_i) state_q <= ENT_EMPTY;
      else                  age_q   <= age_q + 1'b1;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dtt_match.sv
module dtt_match
  import dtt_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int TAG_W  = 1
) (
  input  logic [DEPTH-1:0][1:0]        state_i,
  input  logic [DEPTH-1:0][CMD_W-1:0]  cmd_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
  input  logic [DEPTH-1:0][BE_W-1:0]   be_i,
  input  logic [CMD_W-1:0]             req_cmd_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [BE_W-1:0]              req_be_i,
  output logic [DEPTH-1:0]             hit_vec_o,
  output logic [TAG_W-1:0]             hit_idx_o,
  output logic                         hit_cpl_o,
  output logic [DEPTH-1:0]             free_vec_o
);
  logic [DEPTH-1:0] empty_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign empty_vec[g] = (state_i[g] == ENT_EMPTY);
    assign hit_vec_o[g] = !empty_vec[g] && cmd_i[g] == req_cmd_i &&
                          addr_i[g] == req_addr_i && be_i[g] == req_be_i;
  end

  always_comb begin
    hit_idx_o = '0;
    hit_cpl_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec_o[i]) begin
        hit_idx_o = TAG_W'(i);
        hit_cpl_o = (state_i[i] == ENT_CPL);
      end
    end
  end

  // lowest-numbered free slot wins
  always_comb begin
    free_vec_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (empty_vec[i]) free_vec_o = DEPTH'(1) << i;
    end
  end
endmodule

// File: rtl/dly_txn_tracker.sv
module dly_txn_tracker
  import dtt_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int DATA_W = 32,
  parameter int DISC_W = 16,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DISC_W-1:0] discard_cycles_i,
  input  logic              req_valid_i,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  output logic              rsp_valid_o,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              loc_req_valid_o,
  output logic [TAG_W-1:0]  loc_req_tag_o,
  output logic [CMD_W-1:0]  loc_req_cmd_o,
  output logic [ADDR_W-1:0] loc_req_addr_o,
  output logic [BE_W-1:0]   loc_req_be_o,
  input  logic              loc_cpl_valid_i,
  input  logic [TAG_W-1:0]  loc_cpl_tag_i,
  input  logic [DATA_W-1:0] loc_cpl_data_i
);
  logic [DEPTH-1:0][1:0]        ent_state;
  logic [DEPTH-1:0][CMD_W-1:0]  ent_cmd;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][BE_W-1:0]   ent_be;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0]             hit_vec, free_vec, rec_vec, take_vec;
  logic [TAG_W-1:0]             hit_idx, free_idx;
  logic                         hit_cpl, any_hit, any_free, do_rec;

  dtt_match #(
    .DEPTH(DEPTH), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .BE_W(BE_W), .TAG_W(TAG_W)
  ) u_match (
    .state_i   (ent_state),
    .cmd_i     (ent_cmd),
    .addr_i    (ent_addr),
    .be_i      (ent_be),
    .req_cmd_i (req_cmd_i),
    .req_addr_i(req_addr_i),
    .req_be_i  (req_be_i),
    .hit_vec_o (hit_vec),
    .hit_idx_o (hit_idx),
    .hit_cpl_o (hit_cpl),
    .free_vec_o(free_vec)
  );

  assign any_hit  = |hit_vec;
  assign any_free = |free_vec;
  assign do_rec   = req_valid_i && !any_hit && any_free;

  always_comb begin
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_vec[i]) free_idx = TAG_W'(i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    ent_st_e st_w;
    assign rec_vec[g]   = do_rec && free_vec[g];
    assign take_vec[g]  = req_valid_i && hit_vec[g] && ent_state[g] == ENT_CPL;
    assign ent_state[g] = st_w;

    dtt_entry #(
      .CMD_W(CMD_W), .ADDR_W(ADDR_W), .BE_W(BE_W),
      .DATA_W(DATA_W), .DISC_W(DISC_W)
    ) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rec_i     (rec_vec[g]),
      .rec_cmd_i (req_cmd_i),
      .rec_addr_i(req_addr_i),
      .rec_be_i  (req_be_i),
      .take_i    (take_vec[g]),
      .cpl_i     (loc_cpl_valid_i && loc_cpl_tag_i == TAG_W'(g)),
      .cpl_data_i(loc_cpl_data_i),
      .limit_i   (discard_cycles_i),
      .state_o   (st_w),
      .cmd_o     (ent_cmd[g]),
      .addr_o    (ent_addr[g]),
      .be_o      (ent_be[g]),
      .data_o    (ent_data[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_done_o      <= 1'b0;
      rsp_data_o      <= '1;
      loc_req_valid_o <= 1'b0;
      loc_req_tag_o   <= '0;
      loc_req_cmd_o   <= '0;
      loc_req_addr_o  <= '0;
      loc_req_be_o    <= '0;
    end else begin
      rsp_valid_o     <= req_valid_i;
      rsp_done_o      <= req_valid_i && any_hit && hit_cpl;
      rsp_data_o      <= (req_valid_i && any_hit && hit_cpl) ? ent_data[hit_idx] : '1;
      loc_req_valid_o <= do_rec;
      if (do_rec) begin
        loc_req_tag_o  <= free_idx;
        loc_req_cmd_o  <= req_cmd_i;
        loc_req_addr_o <= req_addr_i;
        loc_req_be_o   <= req_be_i;
      end
    end
  end
endmodule

module dly_txn_tracker_chk #(
  parameter int DEPTH  = 2,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              rsp_valid_o,
  input logic              rsp_done_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              loc_req_valid_o,
  input logic [DEPTH-1:0]  hit_vec,
  input logic [DEPTH-1:0]  free_vec
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_single_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  assert_loc_req_with_retry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_req_valid_o |-> rsp_valid_o && !rsp_done_o);
  assert_full_no_record_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit_vec == '0 && free_vec == '0) |=> !loc_req_valid_o);
  assert_retry_all_ones_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_done_o) |-> rsp_data_o == '1);
  assert_done_needs_rsp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> rsp_valid_o);
endmodule

bind dly_txn_tracker dly_txn_tracker_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_done_o     (rsp_done_o),
  .rsp_data_o     (rsp_data_o),
  .loc_req_valid_o(loc_req_valid_o),
  .hit_vec        (hit_vec),
  .free_vec       (free_vec)
);

// File: tb/dly_txn_tracker_tb.sv
`timescale 1ns/1ps
module dly_txn_tracker_tb;
  localparam int DEPTH = 2, CMD_W = 4, ADDR_W = 32, BE_W = 4, DATA_W = 32, DISC_W = 16;
  localparam int TAG_W = 1;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [DISC_W-1:0] disc = 16'd3;
  logic              rv = 1'b0;
  logic [CMD_W-1:0]  rcmd = '0;
  logic [ADDR_W-1:0] raddr = '0;
  logic [BE_W-1:0]   rbe = '0;
  logic              cv = 1'b0;
  logic [TAG_W-1:0]  ctag = '0;
  logic [DATA_W-1:0] cdata = '0;
  logic              rsp_v, rsp_d, lq_v;
  logic [DATA_W-1:0] rsp_dat;
  logic [TAG_W-1:0]  lq_tag;
  logic [CMD_W-1:0]  lq_cmd;
  logic [ADDR_W-1:0] lq_addr;
  logic [BE_W-1:0]   lq_be;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dly_txn_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .discard_cycles_i(disc),
    .req_valid_i(rv), .req_cmd_i(rcmd), .req_addr_i(raddr), .req_be_i(rbe),
    .rsp_valid_o(rsp_v), .rsp_done_o(rsp_d), .rsp_data_o(rsp_dat),
    .loc_req_valid_o(lq_v), .loc_req_tag_o(lq_tag), .loc_req_cmd_o(lq_cmd),
    .loc_req_addr_o(lq_addr), .loc_req_be_o(lq_be),
    .loc_cpl_valid_i(cv), .loc_cpl_tag_i(ctag), .loc_cpl_data_i(cdata)
  );

  // reference table: 0 free, 1 waiting, 2 holding data
  int          m_st[DEPTH];
  int          m_age[DEPTH];
  logic [CMD_W-1:0]  m_cmd[DEPTH];
  logic [ADDR_W-1:0] m_addr[DEPTH];
  logic [BE_W-1:0]   m_be[DEPTH];
  logic [DATA_W-1:0] m_data[DEPTH];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; drives, predicts, compares 1 ns after the rising edge
  task automatic step(string req, bit v, int cmd, longint addr, int be,
                      bit c, int tag, longint data);
    bit e_v, e_d, e_lq; longint e_dat; int e_tag;
    int hit, freek, rec, take;
    rv = v; rcmd = CMD_W'(cmd); raddr = ADDR_W'(addr); rbe = BE_W'(be);
    cv = c; ctag = TAG_W'(tag); cdata = DATA_W'(data);
    hit = -1; freek = -1; rec = -1; take = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_st[i] != 0 && m_cmd[i] == rcmd && m_addr[i] == raddr && m_be[i] == rbe) hit = i;
    end
    for (int i = DEPTH - 1; i >= 0; i--) if (m_st[i] == 0) freek = i;
    e_v = v; e_d = 0; e_dat = 64'hFFFF_FFFF; e_lq = 0; e_tag = -1;
    if (v && hit >= 0 && m_st[hit] == 2) begin
      e_d = 1; e_dat = m_data[hit]; take = hit;
    end else if (v && hit < 0 && freek >= 0) begin
      e_lq = 1; e_tag = freek; rec = freek;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (i == rec) begin
        m_st[i] = 1; m_cmd[i] = rcmd; m_addr[i] = raddr; m_be[i] = rbe;
      end else if (i == take) m_st[i] = 0;
      else if (m_st[i] == 1 && c && tag == i) begin
        m_st[i] = 2; m_data[i] = cdata; m_age[i] = 0;
      end else if (m_st[i] == 2) begin
        if (m_age[i] == int'(disc)) m_st[i] = 0; else m_age[i]++;
      end
    end
    @(posedge clk); #1;
    chk(req, "rsp_valid", rsp_v, e_v);
    chk(req, "rsp_done", rsp_d, e_d);
    if (e_v) chk(req, "rsp_data", rsp_dat, e_dat);
    chk(req, "loc_req_valid", lq_v, e_lq);
    if (e_lq) begin
      chk(req, "loc_req_tag", lq_tag, e_tag);
      chk(req, "loc_req_cmd", lq_cmd, cmd);
      chk(req, "loc_req_addr", lq_addr, addr);
      chk(req, "loc_req_be", lq_be, be);
    end
    @(negedge clk);
  endtask

  task automatic idle(string req, int n);
    for (int k = 0; k < n; k++) step(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_st[i] = 0; m_age[i] = 0; end
    #35;
    // R10 reset state
    chk("R10", "rsp_valid", rsp_v, 0);
    chk("R10", "loc_req_valid", lq_v, 0);
    @(negedge clk); rst_n = 1'b1;
    idle("R10", 1);
    // R2 first request recorded in slot 0
    step("R2", 1, 6, 32'h100, 4'hF, 0, 0, 0);
    // R4 repeat while pending
    step("R4", 1, 6, 32'h100, 4'hF, 0, 0, 0);
    // R3 same command and address, different byte enables -> new slot 1
    step("R3", 1, 6, 32'h100, 4'h3, 0, 0, 0);
    // R7 table full, other address / command
    step("R7", 1, 6, 32'h104, 4'hF, 0, 0, 0);
    step("R7", 1, 7, 32'h100, 4'hF, 0, 0, 0);
    // R5 completion to slot 0; request on same edge still retried (R4)
    step("R5", 1, 6, 32'h100, 4'hF, 1, 0, 32'hCAFE0001);
    // R5 second completion to a complete slot is ignored
    step("R5", 0, 0, 0, 0, 1, 0, 32'h1234_5678);
    // R6 claim returns stored data, slot freed
    step("R6", 1, 6, 32'h100, 4'hF, 0, 0, 0);
    // R2 freed slot 0 is lowest free; new address recorded there
    step("R2", 1, 7, 32'h200, 4'h1, 0, 0, 0);
    // R9 full-table retry carries all ones
    step("R9", 1, 2, 32'h300, 4'hF, 0, 0, 0);
    // R8 slot 1 completes, claimed on last serving edge (N=3 -> 4th edge)
    step("R8", 0, 0, 0, 0, 1, 1, 32'hBEEF0002);
    idle("R8", 3);
    step("R8", 1, 6, 32'h100, 4'h3, 0, 0, 0);
    // R8 slot 0 completes, window expires, request becomes new
    step("R8", 0, 0, 0, 0, 1, 0, 32'h0000_5A5A);
    idle("R8", 4);
    step("R8", 1, 7, 32'h200, 4'h1, 0, 0, 0);
    // R8 zero hold: served only on the very next edge
    disc = '0;
    step("R8", 0, 0, 0, 0, 1, 0, 32'h7777_0000);
    idle("R8", 1);
    step("R8", 1, 7, 32'h200, 4'h1, 0, 0, 0);
    // R5 completion for a free slot is ignored
    step("R5", 0, 0, 0, 0, 1, 1, 32'h1111_1111);
    step("R5", 1, 6, 32'h100, 4'h3, 0, 0, 0);
    // R1 back-to-back and idle
    idle("R1", 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule